// File: doc/BRIEF.md
# DMA Channel Control and Status Register File

This block is the software-visible register file of a DMA controller that serves up to twelve channels. It stores, for each channel, a transfer mode and a transfer direction, plus one interrupt enable bit. It drives the mode and direction straight out to the channel engines. The engines send back a live two-bit state code, a one-cycle completion pulse and a one-cycle error pulse. The block turns the pulses into sticky flags. Software clears a flag by writing a 1 to its bit.

Access is through a single-cycle 32-bit port indexed by word (byte offset = 4 × `bus_waddr`). A write lands on the next rising clock edge. Reads are combinational from the current register contents. Channels 0–7 live in the "low" control and status words and channels 8 and up live in the "high" ones, so a driver addresses a channel by group (n / 8) and slot (n % 8). One level-sensitive interrupt line goes high while any enabled channel has its completion flag set.

Top module: `dmac_csr`

## Requirements
- R1: While reset is asserted and right after it, every register word reads 0 and `ch_mode`, `ch_to_dev` and `irq` are 0.
- R2: Word 0 (offset 0x00) holds the control nibble of channel n (n < 8) at bits [4n+3:4n]. In that nibble, bits [1:0] are the mode (0 off, 1 descriptor-chained, 2 single transfer) and bit 2 is the direction (1 = memory to device). Bit 3 of every nibble reads 0. `ch_mode[2n+1:2n]` and `ch_to_dev[n]` show the stored fields.
- R3: Word 3 (offset 0x0C) holds the nibbles of channels 8–11, with the same layout, at slot n−8. Its bits above the last channel read 0.
- R4: Word 2 (offset 0x08) holds the interrupt enables: bit n for n < 8 and bit n+8 for n ≥ 8. All other bits read 0.
- R5: Word 4 (offset 0x10) shows the live `eng_state` of channel n < 8 at bits [17+2n:16+2n] (0 idle, 1 descriptor fetch, 2 waiting on device, 3 moving data). Word 6 (offset 0x18) does the same for channels 8–11 at slot n−8. Writes do not change these fields.
- R6: A `done_pulse[n]` sets the completion flag at bit (n % 8) of the channel's status word. A `fault_pulse[n]` sets the error flag at bit (n % 8)+8. The new flag can be read from the cycle after the pulse.
- R7: Writing a 1 to a flag bit clears that flag. Writing a 0 leaves it as it is, so writing back the value just read clears exactly the flags that were seen.
- R8: A pulse that comes in the same cycle as a write clearing the same flag wins, and the flag ends up set.
- R9: `irq` is a register. It goes high one cycle after any channel has both its completion flag and its enable set, and it falls one cycle after no such channel is left. Error flags do not drive `irq`.
- R10: Words 1, 5 and 7 (offsets 0x04, 0x14, 0x1C) always read 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Write strobe, one write per cycle held high |
| bus_waddr | input | 3 | Word index of the register accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_waddr`, combinational |
| eng_state | input | 2*NUM_CH | Live state code of each channel engine |
| done_pulse | input | NUM_CH | Completion event per channel |
| fault_pulse | input | NUM_CH | Error event per channel |
| ch_mode | output | 2*NUM_CH | Transfer mode per channel |
| ch_to_dev | output | NUM_CH | Direction per channel, 1 = memory to device |
| irq | output | 1 | Combined completion interrupt, level, active high |

## Verification
The properties assume that the strobe, the word index and the event pulses are synchronous to the clock and settled at each rising edge. They also assume that a pulse stands for exactly one event per cycle high. A flag is therefore only ever expected to rise after a pulse and to fall only after a write to its word. The stimulus changes every input only on falling edges and holds pulses and writes for one cycle each. It pairs a pulse with a clearing write only where the set-over-clear rule is being tested.

// File: rtl/dmac_csr_pkg.sv
package dmac_csr_pkg;

    localparam int DATA_W       = 32;
    localparam int WADDR_W      = 3;
    localparam int CH_PER_GRP   = 8;
    localparam int NUM_GRP      = 2;
    localparam int NIB_W        = 4;
    localparam int FLAG_ERR_OFS = 8;
    localparam int STATE_LSB    = 16;
    localparam int STATE_W      = 2;
    localparam int IEN_HI_OFS   = 8;

    typedef enum logic [1:0] {
        MODE_OFF    = 2'd0,
        MODE_CHAIN  = 2'd1,
        MODE_SINGLE = 2'd2,
        MODE_RSVD   = 2'd3
    } xfer_mode_e;

    typedef enum logic [1:0] {
        ENG_IDLE  = 2'd0,
        ENG_FETCH = 2'd1,
        ENG_WAIT  = 2'd2,
        ENG_MOVE  = 2'd3
    } eng_state_e;

    typedef enum logic [2:0] {
        W_CTRL_LO = 3'd0,
        W_RSVD_A  = 3'd1,
        W_IEN     = 3'd2,
        W_CTRL_HI = 3'd3,
        W_STAT_LO = 3'd4,
        W_RSVD_B  = 3'd5,
        W_STAT_HI = 3'd6,
        W_RSVD_C  = 3'd7
    } reg_word_e;

    typedef struct packed {
        logic       to_dev;
        xfer_mode_e mode;
    } ch_ctl_t;

    localparam int CTL_W = $bits(ch_ctl_t);

    // Bit of the enable word that belongs to a channel.
    function automatic int ien_bit(input int ch);
        return (ch < CH_PER_GRP) ? ch : ch + IEN_HI_OFS;
    endfunction

endpackage

// File: rtl/dmac_csr_ctl.sv
// Channel control nibbles and interrupt enables.
module dmac_csr_ctl
    import dmac_csr_pkg::*;
#(
    parameter int NUM_CH = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_lo,
    input  logic                    wr_hi,
    input  logic                    wr_ien,
    input  logic [DATA_W-1:0]       wdata,
    output ch_ctl_t [NUM_CH-1:0]    ctl_q,
    output logic    [NUM_CH-1:0]    ien_q
);

    typedef struct packed {
        ch_ctl_t [NUM_CH-1:0] ctl;
        logic    [NUM_CH-1:0] ien;
    } ctl_state_t;

    ctl_state_t st_d, st_q;
    logic       unused_wdata;

    assign unused_wdata = ^wdata;

    always_comb begin
        st_d = st_q;
        for (int n = 0; n < NUM_CH; n++) begin
            if ((n < CH_PER_GRP) ? wr_lo : wr_hi) begin
                st_d.ctl[n] = ch_ctl_t'(wdata[NIB_W*(n % CH_PER_GRP) +: CTL_W]);
            end
            if (wr_ien) begin
                st_d.ien[n] = wdata[ien_bit(n)];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctl_q = st_q.ctl;
    assign ien_q = st_q.ien;

endmodule

// File: rtl/dmac_csr_flags.sv
// Sticky completion/error flags (set beats clear) and the registered interrupt.
module dmac_csr_flags #(
    parameter int NUM_CH = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] done_pulse,
    input  logic [NUM_CH-1:0] fault_pulse,
    input  logic [NUM_CH-1:0] clr_done,
    input  logic [NUM_CH-1:0] clr_fault,
    input  logic [NUM_CH-1:0] ien,
    output logic [NUM_CH-1:0] done_q,
    output logic [NUM_CH-1:0] fault_q,
    output logic              irq_q
);

    typedef struct packed {
        logic [NUM_CH-1:0] done;
        logic [NUM_CH-1:0] fault;
        logic              irq;
    } flag_state_t;

    flag_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.done  = done_pulse  | (st_q.done  & ~clr_done);
        st_d.fault = fault_pulse | (st_q.fault & ~clr_fault);
        st_d.irq   = |(st_q.done & ien);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign done_q  = st_q.done;
    assign fault_q = st_q.fault;
    assign irq_q   = st_q.irq;

endmodule

// File: rtl/dmac_csr_rdmux.sv
// Builds every readable word from the stored state and selects one.
module dmac_csr_rdmux
    import dmac_csr_pkg::*;
#(
    parameter int NUM_CH = 12
) (
    input  logic [WADDR_W-1:0]         waddr,
    input  ch_ctl_t [NUM_CH-1:0]       ctl,
    input  logic [NUM_CH-1:0]          ien,
    input  logic [NUM_CH-1:0]          done,
    input  logic [NUM_CH-1:0]          fault,
    input  logic [STATE_W*NUM_CH-1:0]  eng_state,
    output logic [DATA_W-1:0]          rdata
);

    logic [NUM_GRP-1:0][DATA_W-1:0] ctl_w;
    logic [NUM_GRP-1:0][DATA_W-1:0] stat_w;
    logic [DATA_W-1:0]              ien_w;

    always_comb begin
        ctl_w  = '0;
        stat_w = '0;
        ien_w  = '0;
        for (int n = 0; n < NUM_CH; n++) begin
            ctl_w[n / CH_PER_GRP][NIB_W*(n % CH_PER_GRP) +: CTL_W] = ctl[n];
            ien_w[ien_bit(n)] = ien[n];
            stat_w[n / CH_PER_GRP][n % CH_PER_GRP] = done[n];
            stat_w[n / CH_PER_GRP][(n % CH_PER_GRP) + FLAG_ERR_OFS] = fault[n];
            stat_w[n / CH_PER_GRP][STATE_LSB + STATE_W*(n % CH_PER_GRP) +: STATE_W] =
                eng_state[STATE_W*n +: STATE_W];
        end
    end

    always_comb begin
        case (reg_word_e'(waddr))
            W_CTRL_LO: rdata = ctl_w[0];
            W_CTRL_HI: rdata = ctl_w[1];
            W_IEN:     rdata = ien_w;
            W_STAT_LO: rdata = stat_w[0];
            W_STAT_HI: rdata = stat_w[1];
            default:   rdata = '0;
        endcase
    end

endmodule

// File: rtl/dmac_csr.sv
// Top: word decode, clear-mask mapping, channel outputs.
module dmac_csr
    import dmac_csr_pkg::*;
#(
    parameter int NUM_CH = 12
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        bus_wr,
    input  logic [WADDR_W-1:0]          bus_waddr,
    input  logic [DATA_W-1:0]           bus_wdata,
    output logic [DATA_W-1:0]           bus_rdata,
    input  logic [STATE_W*NUM_CH-1:0]   eng_state,
    input  logic [NUM_CH-1:0]           done_pulse,
    input  logic [NUM_CH-1:0]           fault_pulse,
    output logic [STATE_W*NUM_CH-1:0]   ch_mode,
    output logic [NUM_CH-1:0]           ch_to_dev,
    output logic                        irq
);

    reg_word_e             word;
    logic                  wr_lo, wr_hi, wr_ien;
    logic [NUM_GRP-1:0]    stat_wr;
    ch_ctl_t [NUM_CH-1:0]  ctl_q;
    logic [NUM_CH-1:0]     ien_q;
    logic [NUM_CH-1:0]     done_q, fault_q;
    logic [NUM_CH-1:0]     clr_done, clr_fault;

    assign word       = reg_word_e'(bus_waddr);
    assign wr_lo      = bus_wr && (word == W_CTRL_LO);
    assign wr_hi      = bus_wr && (word == W_CTRL_HI);
    assign wr_ien     = bus_wr && (word == W_IEN);
    assign stat_wr[0] = bus_wr && (word == W_STAT_LO);
    assign stat_wr[1] = bus_wr && (word == W_STAT_HI);

    for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
        localparam int GRP  = n / CH_PER_GRP;
        localparam int SLOT = n % CH_PER_GRP;
        assign clr_done[n]  = stat_wr[GRP] & bus_wdata[SLOT];
        assign clr_fault[n] = stat_wr[GRP] & bus_wdata[SLOT + FLAG_ERR_OFS];
        assign ch_mode[STATE_W*n +: STATE_W] = ctl_q[n].mode;
        assign ch_to_dev[n] = ctl_q[n].to_dev;
    end

    dmac_csr_ctl #(.NUM_CH(NUM_CH)) u_ctl (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_lo  (wr_lo),
        .wr_hi  (wr_hi),
        .wr_ien (wr_ien),
        .wdata  (bus_wdata),
        .ctl_q  (ctl_q),
        .ien_q  (ien_q)
    );

    dmac_csr_flags #(.NUM_CH(NUM_CH)) u_flags (
        .clk         (clk),
        .rst_n       (rst_n),
        .done_pulse  (done_pulse),
        .fault_pulse (fault_pulse),
        .clr_done    (clr_done),
        .clr_fault   (clr_fault),
        .ien         (ien_q),
        .done_q      (done_q),
        .fault_q     (fault_q),
        .irq_q       (irq)
    );

    dmac_csr_rdmux #(.NUM_CH(NUM_CH)) u_rdmux (
        .waddr     (bus_waddr),
        .ctl       (ctl_q),
        .ien       (ien_q),
        .done      (done_q),
        .fault     (fault_q),
        .eng_state (eng_state),
        .rdata     (bus_rdata)
    );

endmodule

// File: rtl/dmac_csr_chk.sv
module dmac_csr_chk
    import dmac_csr_pkg::*;
#(
    parameter int NUM_CH = 12
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       bus_wr,
    input logic [WADDR_W-1:0]         bus_waddr,
    input logic [DATA_W-1:0]          bus_rdata,
    input logic [NUM_CH-1:0]          done_pulse,
    input logic [NUM_CH-1:0]          fault_pulse,
    input logic [STATE_W*NUM_CH-1:0]  ch_mode,
    input logic [NUM_CH-1:0]          ch_to_dev,
    input logic                       irq,
    input logic [NUM_CH-1:0]          done_q,
    input logic [NUM_CH-1:0]          fault_q,
    input logic [NUM_CH-1:0]          ien_q
);

    // R2 / R3: control outputs only move on a write
    a_r2_ctl_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> ($stable(ch_mode) && $stable(ch_to_dev)));

    // R6: an error pulse always leaves its flag set
    a_r6_fault_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_pulse != '0) |=> ((fault_q & $past(fault_pulse)) == $past(fault_pulse)));

    // R8: a completion pulse wins even against a clearing write
    a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (done_pulse != '0) |=> ((done_q & $past(done_pulse)) == $past(done_pulse)));

    // R7: without a write no flag falls
    a_r7_no_write_no_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> (((done_q & $past(done_q)) == $past(done_q)) &&
                     ((fault_q & $past(fault_q)) == $past(fault_q))));

    // R9: interrupt is the registered OR of enabled completion flags
    a_r9_irq_follows: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq == (|($past(done_q) & $past(ien_q)))));

    // R9: with nothing enabled the line stays low
    a_r9_no_enable_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (ien_q == '0) |=> !irq);

    // R10: unused words read zero
    a_r10_rsvd_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_waddr == W_RSVD_A || bus_waddr == W_RSVD_B || bus_waddr == W_RSVD_C)
        |-> (bus_rdata == '0));

endmodule

bind dmac_csr dmac_csr_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_wr      (bus_wr),
    .bus_waddr   (bus_waddr),
    .bus_rdata   (bus_rdata),
    .done_pulse  (done_pulse),
    .fault_pulse (fault_pulse),
    .ch_mode     (ch_mode),
    .ch_to_dev   (ch_to_dev),
    .irq         (irq),
    .done_q      (done_q),
    .fault_q     (fault_q),
    .ien_q       (ien_q)
);

// File: tb/dmac_csr_tb.sv
module dmac_csr_tb;

    localparam int NCH = 12;

    logic              clk;
    logic              rst_n;
    logic              bus_wr;
    logic [2:0]        bus_waddr;
    logic [31:0]       bus_wdata;
    logic [31:0]       bus_rdata;
    logic [2*NCH-1:0]  eng_state;
    logic [NCH-1:0]    done_pulse;
    logic [NCH-1:0]    fault_pulse;
    logic [2*NCH-1:0]  ch_mode;
    logic [NCH-1:0]    ch_to_dev;
    logic              irq;

    dmac_csr #(.NUM_CH(NCH)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_wr      (bus_wr),
        .bus_waddr   (bus_waddr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .eng_state   (eng_state),
        .done_pulse  (done_pulse),
        .fault_pulse (fault_pulse),
        .ch_mode     (ch_mode),
        .ch_to_dev   (ch_to_dev),
        .irq         (irq)
    );

    initial clk = 1'b0;
    always #4 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit run_done = 1'b0;

    typedef struct packed {
        logic        wr;
        logic [2:0]  waddr;
        logic [31:0] data;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 22;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 3'd0, 32'hFFFF_FFFF, 4'd2},
        '{1'b0, 3'd0, 32'h7777_7777, 4'd2},   // R2 bit 3 of each nibble is 0
        '{1'b1, 3'd0, 32'h2106_5A31, 4'd2},
        '{1'b0, 3'd0, 32'h2106_5231, 4'd2},   // R2 mixed pattern
        '{1'b1, 3'd3, 32'hFFFF_FFFF, 4'd3},
        '{1'b0, 3'd3, 32'h0000_7777, 4'd3},   // R3 four channels only
        '{1'b1, 3'd3, 32'h0000_0A5C, 4'd3},
        '{1'b0, 3'd3, 32'h0000_0254, 4'd3},   // R3
        '{1'b1, 3'd2, 32'hFFFF_FFFF, 4'd4},
        '{1'b0, 3'd2, 32'h000F_00FF, 4'd4},   // R4 enable positions
        '{1'b1, 3'd1, 32'hFFFF_FFFF, 4'd10},
        '{1'b0, 3'd1, 32'h0000_0000, 4'd10},  // R10
        '{1'b0, 3'd0, 32'h2106_5231, 4'd10},  // R10 nothing else moved
        '{1'b1, 3'd5, 32'hFFFF_FFFF, 4'd10},
        '{1'b0, 3'd5, 32'h0000_0000, 4'd10},
        '{1'b1, 3'd7, 32'hFFFF_FFFF, 4'd10},
        '{1'b0, 3'd7, 32'h0000_0000, 4'd10},
        '{1'b0, 3'd3, 32'h0000_0254, 4'd10},
        '{1'b1, 3'd2, 32'h0000_0000, 4'd4},
        '{1'b0, 3'd2, 32'h0000_0000, 4'd4},
        '{1'b1, 3'd2, 32'h0002_0004, 4'd4},
        '{1'b0, 3'd2, 32'h0002_0004, 4'd4}    // R4 ch2 and ch9 enabled
    };

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        bus_wr    = 1'b1;
        bus_waddr = a;
        bus_wdata = d;
        @(negedge clk);
        bus_wr    = 1'b0;
        bus_wdata = '0;
    endtask

    task automatic rd_chk(input string req, input logic [2:0] a, input logic [31:0] exp);
        bus_waddr = a;
        #1;
        chk(req, $sformatf("read word %0d", a), bus_rdata, exp);
    endtask

    task automatic pulse(input logic [NCH-1:0] dm, input logic [NCH-1:0] fm);
        done_pulse  = dm;
        fault_pulse = fm;
        @(negedge clk);
        done_pulse  = '0;
        fault_pulse = '0;
    endtask

    task automatic wr_pulse(input logic [2:0] a, input logic [31:0] d,
                            input logic [NCH-1:0] dm, input logic [NCH-1:0] fm);
        bus_wr      = 1'b1;
        bus_waddr   = a;
        bus_wdata   = d;
        done_pulse  = dm;
        fault_pulse = fm;
        @(negedge clk);
        bus_wr      = 1'b0;
        bus_wdata   = '0;
        done_pulse  = '0;
        fault_pulse = '0;
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!run_done) begin
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] c0_wr;
        logic [31:0] c3_wr;
        rst_n       = 1'b0;
        bus_wr      = 1'b0;
        bus_waddr   = '0;
        bus_wdata   = '0;
        eng_state   = '0;
        done_pulse  = '0;
        fault_pulse = '0;
        repeat (3) @(negedge clk);

        // R1: reset state
        for (int w = 0; w < 8; w++) rd_chk("R1", 3'(w), 32'h0);
        chk("R1", "ch_mode", 32'(ch_mode), 32'h0);
        chk("R1", "irq", 32'(irq), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk: control, enable, reserved words
        for (int i = 0; i < NV; i++) begin
            if (VECS[i].wr) wr(VECS[i].waddr, VECS[i].data);
            else rd_chk($sformatf("R%0d", VECS[i].req), VECS[i].waddr, VECS[i].data);
        end

        // R2 / R3: channel outputs from the nibbles written
        c0_wr = 32'h2106_5A31;
        c3_wr = 32'h0000_0A5C;
        for (int n = 0; n < NCH; n++) begin
            logic [3:0] nib;
            nib = (n < 8) ? c0_wr[4*n +: 4] : c3_wr[4*(n-8) +: 4];
            chk((n < 8) ? "R2" : "R3", $sformatf("ch%0d mode", n),
                32'(ch_mode[2*n +: 2]), 32'(nib[1:0]));
            chk((n < 8) ? "R2" : "R3", $sformatf("ch%0d dir", n),
                32'(ch_to_dev[n]), 32'(nib[2]));
        end

        // R5: live state fields, read-only
        eng_state = 24'hE4E4E4;
        rd_chk("R5", 3'd4, 32'hE4E4_0000);
        rd_chk("R5", 3'd6, 32'h00E4_0000);
        wr(3'd4, 32'hFFFF_FFFF);
        rd_chk("R5", 3'd4, 32'hE4E4_0000);
        eng_state = '0;

        // R6: done ch3, fault ch5 and ch10
        pulse(12'h008, 12'h420);
        rd_chk("R6", 3'd4, 32'h0000_2008);
        rd_chk("R6", 3'd6, 32'h0000_0400);
        @(negedge clk);
        chk("R9", "irq from unenabled/error flags", 32'(irq), 32'h0);

        // R7: write-one-to-clear
        wr(3'd4, 32'h0000_0008);
        rd_chk("R7", 3'd4, 32'h0000_2000);
        wr(3'd6, 32'h0000_0000);
        rd_chk("R7", 3'd6, 32'h0000_0400);
        wr(3'd6, 32'h0000_0400);
        rd_chk("R7", 3'd6, 32'h0000_0000);
        wr(3'd4, 32'h0000_2000);
        rd_chk("R7", 3'd4, 32'h0000_0000);

        // R8: set beats clear
        pulse(12'h001, 12'h000);
        wr_pulse(3'd4, 32'h0000_0001, 12'h001, 12'h000);
        rd_chk("R8", 3'd4, 32'h0000_0001);
        wr_pulse(3'd4, 32'h0000_0002, 12'h002, 12'h000);
        rd_chk("R8", 3'd4, 32'h0000_0003);
        wr_pulse(3'd6, 32'h0000_0100, 12'h000, 12'h100);
        rd_chk("R8", 3'd6, 32'h0000_0100);
        wr(3'd4, 32'h0000_0003);
        wr(3'd6, 32'h0000_0100);
        rd_chk("R7", 3'd4, 32'h0000_0000);

        // R9: interrupt timing (ch9 enabled)
        pulse(12'h200, 12'h000);
        chk("R9", "irq one cycle after flag", 32'(irq), 32'h0);
        rd_chk("R6", 3'd6, 32'h0000_0002);
        @(negedge clk);
        chk("R9", "irq raised", 32'(irq), 32'h1);
        wr(3'd6, 32'h0000_0002);
        chk("R9", "irq still high after clear edge", 32'(irq), 32'h1);
        @(negedge clk);
        chk("R9", "irq dropped", 32'(irq), 32'h0);

        // R9: enabling after the flag is set
        pulse(12'h800, 12'h000);
        @(negedge clk);
        chk("R9", "ch11 not enabled", 32'(irq), 32'h0);
        wr(3'd2, 32'h000A_0004);
        @(negedge clk);
        chk("R9", "late enable raises irq", 32'(irq), 32'h1);

        // R1: reset in mid-run
        rst_n = 1'b0;
        #1;
        for (int w = 0; w < 8; w++) rd_chk("R1", 3'(w), 32'h0);
        chk("R1", "irq in reset", 32'(irq), 32'h0);
        chk("R1", "ch_to_dev in reset", 32'(ch_to_dev), 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        run_done = 1'b1;
        summary();
        $finish;
    end

endmodule